// File: doc/BRIEF.md
# Five-Slot VLIW Integer Bundle Unit

This block executes one very-long-instruction-word bundle per clock. A bundle holds five ALU operations and one branch operation. All of them share one register file of 32-bit scalar registers. Slots 0 to 3 are general integer lanes. Slot 4 is the special lane: it has everything the general lanes have, and it alone can multiply, shift, divide and convert a 32-bit float to a 32-bit integer. The sixth operation is a branch. It tests one register for zero or non-zero and either loads the program counter with a target or advances it by one bundle.

Every ALU operation in a bundle reads the register values that existed before the bundle, so the five operations may be fully independent. When several slots write the same register, the write from the highest-numbered slot is kept. Unsigned division takes 32 cycles in a serial unit. While it runs, the block lowers its ready output and accepts no bundle. A debug read port returns any register combinationally, so software or a bench can see the architectural state.

Top module: `vliw_bundle_unit`

## Requirements
- R1: After reset the program counter is 0, `bundle_ready` is 1 and every register reads 0.
- R2: Bundle layout. ALU slot k occupies bits [19k+18:19k]: opcode [3:0], destination [8:4], source A [13:9], source B [18:14]. The branch field holds the mode at [96:95], the condition register at [101:97] and the target at [117:102].
- R3: All five slots execute opcode 0 NOP, 1 ADD (A+B), 2 SUB (A-B), 3 AND, 4 OR, 5 XOR, 6 MOV (A) and 7 LDI. LDI writes the 10-bit value {source B field, source A field}, sign-extended. The result is readable on the debug port after the clock edge that accepts the bundle.
- R4: Every ALU operand and the branch condition use the register values from before the bundle; for example two MOVs in one bundle swap two registers.
- R5: When several slots of one bundle write the same register, the highest-numbered slot's value is kept.
- R6: Opcodes 8 to 13 placed in slots 0 to 3 write no register and do not start a division.
- R7: In slot 4, opcode 8 MUL writes the low 32 bits of A*B. Opcode 9 SHL, 10 SHR (logical) and 11 SRA (arithmetic) shift A by B[4:0].
- R8: In slot 4, opcode 12 DIVU starts an unsigned division A/B. `bundle_ready` is 0 for exactly 32 cycles after the accepting edge. The quotient is written at the edge that ends that window, and a zero divisor gives 0xFFFFFFFF. The other slots and the branch of that bundle commit at the accepting edge.
- R9: In slot 4, opcode 13 F2I converts A, read as an IEEE single, to a signed 32-bit integer with truncation toward zero. An exponent field of 0 (zero or denormal) gives 0.
- R10: F2I saturates. Positive infinity and positive values of 2^31 or more give 0x7FFFFFFF. Negative infinity and negative values of -2^31 or below give 0x80000000. A NaN gives 0.
- R11: Branch modes: 0 none, 1 taken when the condition register is 0, 2 taken when it is non-zero, 3 always taken. A taken branch loads the target into the program counter; otherwise the counter advances by 1.
- R12: While `bundle_valid` is 0 or `bundle_ready` is 0, the bundle is ignored: neither the program counter nor any register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bundle_valid | input | 1 | A bundle is offered this cycle |
| bundle | input | 118 | Encoded bundle (layout in R2) |
| bundle_ready | output | 1 | Block can accept a bundle this cycle |
| pc | output | 16 | Program counter of the next bundle |
| dbg_addr | input | 5 | Debug register select |
| dbg_data | output | 32 | Value of the selected register |

## Verification
The assertions assume that `bundle`, `bundle_valid` and `dbg_addr` change only away from the rising edge and that reset is applied before the first bundle. The stall-window and debug-hold properties also assume that no register write can happen while the block is ready and idle. The bench drives all inputs on the falling edge and reads the debug port a moment later. On purpose, it keeps a different bundle valid during the first cycles of a division stall, to show that such a bundle is dropped rather than queued. Constants wider than the 10-bit immediate are built from LDI, SHL and OR bundles, so every value the bench checks comes from the block's own instructions.

// File: rtl/vliw_pkg.sv
package vliw_pkg;
    // Word width of the scalar register file and every datapath
    localparam int WORD_W    = 32;
    // Opcode field width per ALU slot
    localparam int OP_W      = 4;
    // Number of ALU slots, number of general slots, index of the special slot
    localparam int N_ALU     = 5;
    localparam int N_GEN     = 4;
    localparam int SPEC_SLOT = 4;
    // Shift amount width derived from the word width
    localparam int SH_W      = $clog2(WORD_W);

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_MOV  = 4'd6,
        OP_LDI  = 4'd7,
        OP_MUL  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10,
        OP_SRA  = 4'd11,
        OP_DIVU = 4'd12,
        OP_F2I  = 4'd13
    } alu_op_e;

    typedef enum logic [1:0] {
        BR_NONE    = 2'd0,
        BR_ZERO    = 2'd1,
        BR_NONZERO = 2'd2,
        BR_ALWAYS  = 2'd3
    } br_mode_e;
endpackage

// File: rtl/vliw_regfile.sv
// Scalar register file with many combinational read ports and prioritised
// write ports. Assumes: write port p outranks every port below p when two
// ports hit the same register in one cycle. Reset clears every register.
module vliw_regfile
    import vliw_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int N_WP   = 6,
    parameter int N_RP   = 12,
    localparam int N_REGS = 1 << REG_AW
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_WP-1:0]                   we,
    input  logic [N_WP-1:0][REG_AW-1:0]       waddr,
    input  logic [N_WP-1:0][WORD_W-1:0]       wdata,
    input  logic [N_RP-1:0][REG_AW-1:0]       raddr,
    output logic [N_RP-1:0][WORD_W-1:0]       rdata
);
    logic [WORD_W-1:0] regs [N_REGS];

    // Write ports applied in ascending order so the highest port lands last
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) regs[i] <= '0;
        end else begin
            for (int p = 0; p < N_WP; p++) begin
                if (we[p]) regs[waddr[p]] <= wdata[p];
            end
        end
    end

    // One combinational read mux per read port
    for (genvar p = 0; p < N_RP; p++) begin : g_rd
        assign rdata[p] = regs[raddr[p]];
    end
endmodule

// File: rtl/vliw_gen_alu.sv
// General integer lane: add, subtract, logic ops, move and a sign-extended
// short immediate load. Assumes operands are already fetched; purely
// combinational. Any opcode outside its set gives we = 0.
module vliw_gen_alu
    import vliw_pkg::*;
#(
    parameter int IMM_W = 10
) (
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic              we,
    output logic [WORD_W-1:0] res
);
    // Select the result of the general operation set
    always_comb begin
        we  = 1'b1;
        res = '0;
        case (alu_op_e'(op))
            OP_ADD: res = opa + opb;
            OP_SUB: res = opa - opb;
            OP_AND: res = opa & opb;
            OP_OR:  res = opa | opb;
            OP_XOR: res = opa ^ opb;
            OP_MOV: res = opa;
            OP_LDI: res = {{(WORD_W-IMM_W){imm[IMM_W-1]}}, imm};
            default: we = 1'b0;
        endcase
    end
endmodule

// File: rtl/vliw_spec_alu.sv
// Special lane: the general set plus multiply, shifts and float-to-integer
// conversion. Division is only flagged here (div_start); the serial divider
// performs it. Assumes WORD_W is 32 for the float conversion.
module vliw_spec_alu
    import vliw_pkg::*;
#(
    parameter int IMM_W = 10
) (
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic              we,
    output logic              div_start,
    output logic [WORD_W-1:0] res
);
    logic              gen_we;
    logic [WORD_W-1:0] gen_res;

    vliw_gen_alu #(.IMM_W(IMM_W)) u_gen (
        .op  (op),
        .opa (opa),
        .opb (opb),
        .imm (imm),
        .we  (gen_we),
        .res (gen_res)
    );

    // Float to signed integer, truncating, with saturation and NaN to zero
    function automatic logic [31:0] to_int(input logic [31:0] f);
        logic        sgn;
        logic [7:0]  ex;
        logic [22:0] man;
        logic [31:0] mag;
        int          e;
        sgn = f[31];
        ex  = f[30:23];
        man = f[22:0];
        e   = int'(ex) - 127;
        mag = {8'd0, 1'b1, man};
        if (ex == 8'd0) return '0;
        if (ex == 8'hFF) return (man != '0) ? 32'd0 : (sgn ? 32'h8000_0000 : 32'h7FFF_FFFF);
        if (e < 0) return '0;
        if (e >= 31) return sgn ? 32'h8000_0000 : 32'h7FFF_FFFF;
        if (e >= 23) mag = mag << (e - 23);
        else         mag = mag >> (23 - e);
        return sgn ? (~mag + 32'd1) : mag;
    endfunction

    // Extend the general result with the special-only operations
    always_comb begin
        we        = gen_we;
        res       = gen_res;
        div_start = 1'b0;
        case (alu_op_e'(op))
            OP_MUL: begin we = 1'b1; res = opa * opb; end
            OP_SHL: begin we = 1'b1; res = opa << opb[SH_W-1:0]; end
            OP_SHR: begin we = 1'b1; res = opa >> opb[SH_W-1:0]; end
            OP_SRA: begin we = 1'b1; res = $signed(opa) >>> opb[SH_W-1:0]; end
            OP_F2I: begin we = 1'b1; res = to_int(opa); end
            OP_DIVU: begin we = 1'b0; div_start = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/vliw_serial_div.sv
// Restoring unsigned divider, one quotient bit per cycle, W cycles per
// division. Assumes start is only raised while busy is low. A zero divisor
// naturally yields an all-ones quotient. done pulses in the last busy cycle,
// with the final quotient on quotient in that same cycle.
module vliw_serial_div #(
    parameter int W     = 32,
    parameter int TAG_W = 5,
    localparam int CNT_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     dividend,
    input  logic [W-1:0]     divisor,
    input  logic [TAG_W-1:0] tag_in,
    output logic             busy,
    output logic             done,
    output logic [W-1:0]     quotient,
    output logic [TAG_W-1:0] tag
);
    logic [W-1:0]     q_r, d_r, r_r, trial, r_nxt, q_nxt;
    logic [W:0]       shifted;
    logic             fit;
    logic [CNT_W-1:0] cnt_r;
    logic             busy_r;
    logic [TAG_W-1:0] tag_r;

    // One restoring step: shift in the next dividend bit and try subtracting
    always_comb begin
        shifted = {r_r, q_r[W-1]};
        fit     = shifted >= {1'b0, d_r};
        trial   = shifted[W-1:0] - d_r;
        r_nxt   = fit ? trial : shifted[W-1:0];
        q_nxt   = {q_r[W-2:0], fit};
    end

    // Load operands on start, then iterate until the last bit is resolved
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r    <= '0;
            d_r    <= '0;
            r_r    <= '0;
            cnt_r  <= '0;
            busy_r <= 1'b0;
            tag_r  <= '0;
        end else if (start && !busy_r) begin
            q_r    <= dividend;
            d_r    <= divisor;
            r_r    <= '0;
            cnt_r  <= '0;
            busy_r <= 1'b1;
            tag_r  <= tag_in;
        end else if (busy_r) begin
            q_r   <= q_nxt;
            r_r   <= r_nxt;
            cnt_r <= cnt_r + 1'b1;
            if (cnt_r == CNT_W'(W-1)) busy_r <= 1'b0;
        end
    end

    assign busy     = busy_r;
    assign done     = busy_r && (cnt_r == CNT_W'(W-1));
    assign quotient = q_nxt;
    assign tag      = tag_r;
endmodule

// File: rtl/vliw_bundle_unit.sv
// Top level: decodes a bundle of five ALU slots and one branch slot, fetches
// all operands from the pre-bundle register state, executes every slot, writes
// back with higher slots outranking lower ones, and updates the program
// counter. Assumes the bundle is held stable around the accepting edge.
// The divider's late write uses the highest-priority port; no other write can
// coincide with it because issue is stalled while it runs.
module vliw_bundle_unit
    import vliw_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int PC_W   = 16,
    localparam int IMM_W    = 2 * REG_AW,
    localparam int SLOT_W   = OP_W + 3 * REG_AW,
    localparam int BR_LSB   = N_ALU * SLOT_W,
    localparam int BUNDLE_W = BR_LSB + 2 + REG_AW + PC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bundle_valid,
    input  logic [BUNDLE_W-1:0] bundle,
    output logic                bundle_ready,
    output logic [PC_W-1:0]     pc,
    input  logic [REG_AW-1:0]   dbg_addr,
    output logic [WORD_W-1:0]   dbg_data
);
    localparam int N_WP   = N_ALU + 1;
    localparam int N_RP   = 2 * N_ALU + 2;
    localparam int RP_BR  = 2 * N_ALU;
    localparam int RP_DBG = 2 * N_ALU + 1;
    localparam int WP_DIV = N_ALU;

    logic                        accept;
    logic [N_ALU-1:0][OP_W-1:0]   s_op;
    logic [N_ALU-1:0][REG_AW-1:0] s_dst, s_sa, s_sb;
    logic [N_ALU-1:0][WORD_W-1:0] s_res;
    logic [N_ALU-1:0]             s_we;
    logic                         div_req;

    logic [N_WP-1:0]              rf_we;
    logic [N_WP-1:0][REG_AW-1:0]  rf_waddr;
    logic [N_WP-1:0][WORD_W-1:0]  rf_wdata;
    logic [N_RP-1:0][REG_AW-1:0]  rf_raddr;
    logic [N_RP-1:0][WORD_W-1:0]  rf_rdata;

    logic              div_busy, div_done;
    logic [WORD_W-1:0] div_q;
    logic [REG_AW-1:0] div_tag;

    logic [1:0]        br_mode;
    logic [REG_AW-1:0] br_reg;
    logic [PC_W-1:0]   br_tgt;
    logic              br_taken;
    logic [PC_W-1:0]   pc_r;

    assign bundle_ready = !div_busy;
    assign accept       = bundle_valid && !div_busy;

    // Per-slot field decode, operand fetch and execution
    for (genvar k = 0; k < N_ALU; k++) begin : g_slot
        assign s_op[k]  = bundle[k*SLOT_W +: OP_W];
        assign s_dst[k] = bundle[k*SLOT_W + OP_W +: REG_AW];
        assign s_sa[k]  = bundle[k*SLOT_W + OP_W + REG_AW +: REG_AW];
        assign s_sb[k]  = bundle[k*SLOT_W + OP_W + 2*REG_AW +: REG_AW];

        assign rf_raddr[2*k]   = s_sa[k];
        assign rf_raddr[2*k+1] = s_sb[k];

        assign rf_we[k]    = accept && s_we[k];
        assign rf_waddr[k] = s_dst[k];
        assign rf_wdata[k] = s_res[k];

        if (k == SPEC_SLOT) begin : g_spec
            vliw_spec_alu #(.IMM_W(IMM_W)) u_alu (
                .op        (s_op[k]),
                .opa       (rf_rdata[2*k]),
                .opb       (rf_rdata[2*k+1]),
                .imm       ({s_sb[k], s_sa[k]}),
                .we        (s_we[k]),
                .div_start (div_req),
                .res       (s_res[k])
            );
        end else begin : g_gen
            vliw_gen_alu #(.IMM_W(IMM_W)) u_alu (
                .op  (s_op[k]),
                .opa (rf_rdata[2*k]),
                .opb (rf_rdata[2*k+1]),
                .imm ({s_sb[k], s_sa[k]}),
                .we  (s_we[k]),
                .res (s_res[k])
            );
        end
    end

    // Branch field decode
    assign br_mode = bundle[BR_LSB +: 2];
    assign br_reg  = bundle[BR_LSB + 2 +: REG_AW];
    assign br_tgt  = bundle[BR_LSB + 2 + REG_AW +: PC_W];

    assign rf_raddr[RP_BR]  = br_reg;
    assign rf_raddr[RP_DBG] = dbg_addr;
    assign dbg_data         = rf_rdata[RP_DBG];

    // Late division result takes the top write port
    assign rf_we[WP_DIV]    = div_done;
    assign rf_waddr[WP_DIV] = div_tag;
    assign rf_wdata[WP_DIV] = div_q;

    vliw_regfile #(.REG_AW(REG_AW), .N_WP(N_WP), .N_RP(N_RP)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    vliw_serial_div #(.W(WORD_W), .TAG_W(REG_AW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept && div_req),
        .dividend (rf_rdata[2*SPEC_SLOT]),
        .divisor  (rf_rdata[2*SPEC_SLOT+1]),
        .tag_in   (s_dst[SPEC_SLOT]),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_q),
        .tag      (div_tag)
    );

    // Evaluate the branch condition on the pre-bundle register value
    always_comb begin
        case (br_mode_e'(br_mode))
            BR_ZERO:    br_taken = (rf_rdata[RP_BR] == '0);
            BR_NONZERO: br_taken = (rf_rdata[RP_BR] != '0);
            BR_ALWAYS:  br_taken = 1'b1;
            default:    br_taken = 1'b0;
        endcase
    end

    // Program counter: load target or step once per accepted bundle
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_r <= '0;
        else if (accept) pc_r <= br_taken ? br_tgt : pc_r + 1'b1;
    end

    assign pc = pc_r;
endmodule

// File: rtl/vliw_bundle_checks.sv
// Protocol checker bound to the bundle unit. Observes ports only and keeps
// its own count of stall cycles to check the division window length.
module vliw_bundle_checks
    import vliw_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int PC_W   = 16,
    localparam int SLOT_W   = OP_W + 3 * REG_AW,
    localparam int BR_LSB   = N_ALU * SLOT_W,
    localparam int BUNDLE_W = BR_LSB + 2 + REG_AW + PC_W,
    localparam int CNT_W    = $clog2(WORD_W) + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bundle_valid,
    input logic [BUNDLE_W-1:0] bundle,
    input logic                bundle_ready,
    input logic [PC_W-1:0]     pc,
    input logic [REG_AW-1:0]   dbg_addr,
    input logic [WORD_W-1:0]   dbg_data
);
    logic            acc;
    logic [1:0]      mode;
    logic [PC_W-1:0] tgt;
    logic [OP_W-1:0] op4;
    logic [CNT_W-1:0] stall_cnt;

    assign acc  = bundle_valid && bundle_ready;
    assign mode = bundle[BR_LSB +: 2];
    assign tgt  = bundle[BR_LSB + 2 + REG_AW +: PC_W];
    assign op4  = bundle[SPEC_SLOT*SLOT_W +: OP_W];

    // Count consecutive not-ready cycles
    always_ff @(posedge clk) begin
        if (!rst_n)             stall_cnt <= '0;
        else if (!bundle_ready) stall_cnt <= stall_cnt + 1'b1;
        else                    stall_cnt <= '0;
    end

    a_r12_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(pc));

    a_r12_dbg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bundle_ready && !bundle_valid) |=> (!$stable(dbg_addr) || $stable(dbg_data)));

    a_r11_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode == 2'd0) |=> pc == PC_W'($past(pc) + 1'b1));

    a_r11_pc_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode == 2'd3) |=> pc == $past(tgt));

    a_r8_div_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op4 == OP_W'(12)) |=> !bundle_ready);

    a_r8_stall_body: assert property (@(posedge clk) disable iff (!rst_n)
        (!bundle_ready && stall_cnt < CNT_W'(WORD_W-1)) |=> !bundle_ready);

    a_r8_stall_end: assert property (@(posedge clk) disable iff (!rst_n)
        (!bundle_ready && stall_cnt == CNT_W'(WORD_W-1)) |=> bundle_ready);
endmodule

bind vliw_bundle_unit vliw_bundle_checks #(.REG_AW(REG_AW), .PC_W(PC_W)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .bundle_valid (bundle_valid),
    .bundle       (bundle),
    .bundle_ready (bundle_ready),
    .pc           (pc),
    .dbg_addr     (dbg_addr),
    .dbg_data     (dbg_data)
);

// File: tb/test_vliw_bundle_unit.sv
module test_vliw_bundle_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         bundle_valid;
    logic [117:0] bundle;
    logic         bundle_ready;
    logic [15:0]  pc;
    logic [4:0]   dbg_addr;
    logic [31:0]  dbg_data;

    int          n_chk = 0;
    int          n_err = 0;
    logic        finished = 1'b0;
    logic [15:0] exp_pc = '0;

    localparam logic [3:0] NOP = 4'd0, ADD = 4'd1, SUB = 4'd2, AND_ = 4'd3, OR_ = 4'd4,
                           XOR_ = 4'd5, MOV = 4'd6, MUL = 4'd8, SHL = 4'd9,
                           SHR = 4'd10, SRA = 4'd11, DIVU = 4'd12, F2I = 4'd13;

    always #5 clk = ~clk;

    vliw_bundle_unit i_vliw_bundle_unit (
        .clk          (clk),
        .rst_n        (rst_n),
        .bundle_valid (bundle_valid),
        .bundle       (bundle),
        .bundle_ready (bundle_ready),
        .pc           (pc),
        .dbg_addr     (dbg_addr),
        .dbg_data     (dbg_data)
    );

    function automatic logic [18:0] sl(input logic [3:0] op, input logic [4:0] d, a, b);
        return {b, a, d, op};
    endfunction

    function automatic logic [18:0] ldi(input logic [4:0] d, input int v);
        logic [9:0] im;
        im = v[9:0];
        return {im[9:5], im[4:0], d, 4'd7};
    endfunction

    function automatic logic [117:0] bun(input logic [18:0] s0, s1, s2, s3, s4,
                                         input logic [1:0] m, input logic [4:0] cr,
                                         input logic [15:0] t);
        return {t, cr, m, s4, s3, s2, s1, s0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [4:0] a, input logic [31:0] exp);
        dbg_addr = a;
        #1;
        chk(tag, dbg_data, exp);
    endtask

    // Offer one bundle for one cycle; ends on the falling edge after acceptance
    task automatic issue(input logic [117:0] b);
        @(negedge clk);
        bundle_valid = 1'b1;
        bundle       = b;
        @(negedge clk);
        bundle_valid = 1'b0;
        exp_pc       = exp_pc + 16'd1;
    endtask

    task automatic wait_ready();
        while (!bundle_ready) @(negedge clk);
    endtask

    // Build a full 32-bit constant with LDI, SHL and OR (uses r30, r31)
    task automatic load_const(input logic [4:0] r, input logic [31:0] v);
        issue(bun(ldi(31, 8), ldi(r, int'(v[31:24])), '0, '0, '0, 2'd0, 5'd0, 16'd0));
        for (int i = 2; i >= 0; i--) begin
            issue(bun(ldi(30, int'(v[i*8 +: 8])), '0, '0, '0, sl(SHL, r, r, 31), 2'd0, 5'd0, 16'd0));
            issue(bun(sl(OR_, r, r, 30), '0, '0, '0, '0, 2'd0, 5'd0, 16'd0));
        end
    endtask

    task automatic t_reset();
        chk("R1 pc", 32'(pc), 32'd0);
        chk("R1 ready", 32'(bundle_ready), 32'd1);
        chk_reg("R1 r5", 5, 32'd0);
        chk_reg("R1 r31", 31, 32'd0);
    endtask

    task automatic t_general();
        issue(bun(ldi(1, 5), ldi(2, -3), ldi(3, 100), ldi(4, 7), ldi(5, 1), 2'd0, 5'd0, 16'd0));
        chk_reg("R3 LDI positive", 1, 32'd5);
        chk_reg("R3 LDI sign-extended", 2, 32'hFFFF_FFFD);
        chk_reg("R3 LDI slot4", 5, 32'd1);
        issue(bun(sl(ADD, 6, 1, 2), sl(SUB, 7, 1, 2), sl(AND_, 8, 3, 4), sl(XOR_, 9, 3, 4),
                  sl(OR_, 10, 1, 3), 2'd0, 5'd0, 16'd0));
        chk_reg("R3 ADD slot0", 6, 32'd2);
        chk_reg("R3 SUB slot1", 7, 32'd8);
        chk_reg("R2 AND slot2", 8, 32'd4);
        chk_reg("R2 XOR slot3", 9, 32'd99);
        chk_reg("R2 OR slot4", 10, 32'd101);
        chk("R11 pc step", 32'(pc), 32'(exp_pc));
    endtask

    task automatic t_swap();
        issue(bun(sl(MOV, 1, 2, 0), sl(MOV, 2, 1, 0), '0, '0, '0, 2'd0, 5'd0, 16'd0));
        chk_reg("R4 swap r1", 1, 32'hFFFF_FFFD);
        chk_reg("R4 swap r2", 2, 32'd5);
    endtask

    task automatic t_conflict();
        issue(bun(ldi(12, 1), ldi(11, 10), ldi(11, 30), ldi(11, 20), ldi(12, 2), 2'd0, 5'd0, 16'd0));
        chk_reg("R5 slot3 over slots 1,2", 11, 32'd20);
        chk_reg("R5 slot4 over slot0", 12, 32'd2);
    endtask

    task automatic t_unsupported();
        issue(bun(ldi(13, 77), '0, '0, '0, '0, 2'd0, 5'd0, 16'd0));
        issue(bun(sl(MUL, 13, 1, 1), sl(SHL, 13, 1, 1), sl(F2I, 14, 1, 0), sl(DIVU, 13, 1, 1), '0,
                  2'd0, 5'd0, 16'd0));
        chk_reg("R6 r13 untouched", 13, 32'd77);
        chk_reg("R6 r14 untouched", 14, 32'd0);
        chk("R6 no stall", 32'(bundle_ready), 32'd1);
    endtask

    task automatic t_mul_shift();
        issue(bun(ldi(15, 300), ldi(16, -200), ldi(19, 36), ldi(20, 2), '0, 2'd0, 5'd0, 16'd0));
        issue(bun('0, '0, '0, '0, sl(MUL, 17, 15, 16), 2'd0, 5'd0, 16'd0));
        chk_reg("R7 MUL signed pattern", 17, 32'hFFFF_15A0);
        issue(bun('0, '0, '0, '0, sl(SHL, 18, 15, 19), 2'd0, 5'd0, 16'd0));
        chk_reg("R7 SHL uses B[4:0]", 18, 32'd4800);
        issue(bun('0, '0, '0, '0, sl(SRA, 21, 16, 20), 2'd0, 5'd0, 16'd0));
        chk_reg("R7 SRA", 21, 32'hFFFF_FFCE);
        issue(bun('0, '0, '0, '0, sl(SHR, 22, 16, 20), 2'd0, 5'd0, 16'd0));
        chk_reg("R7 SHR", 22, 32'h3FFF_FFCE);
        load_const(12, 32'h0001_0001);
        issue(bun('0, '0, '0, '0, sl(MUL, 11, 12, 12), 2'd0, 5'd0, 16'd0));
        chk_reg("R7 MUL low half", 11, 32'h0002_0001);
    endtask

    task automatic t_div();
        int stall;
        issue(bun(ldi(23, 500), ldi(24, 7), '0, '0, '0, 2'd0, 5'd0, 16'd0));
        @(negedge clk);
        bundle_valid = 1'b1;
        bundle = bun(ldi(25, 9), '0, '0, '0, sl(DIVU, 26, 23, 24), 2'd3, 5'd0, 16'h0040);
        @(negedge clk);
        // a different bundle stays offered during the stall and must be dropped
        bundle = bun(ldi(27, 55), '0, '0, '0, '0, 2'd3, 5'd0, 16'h0777);
        exp_pc = 16'h0040;
        stall = 0;
        if (!bundle_ready) stall = 1;
        chk("R8 stall starts", 32'(bundle_ready), 32'd0);
        chk("R8 branch commits at issue", 32'(pc), 32'h40);
        chk_reg("R8 sibling slot commits at issue", 25, 32'd9);
        chk_reg("R8 quotient not yet written", 26, 32'd0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!bundle_ready) stall++;
        end
        chk_reg("R12 stalled bundle ignored", 27, 32'd0);
        chk("R12 pc held in stall", 32'(pc), 32'h40);
        bundle_valid = 1'b0;
        for (int i = 0; i < 100 && !bundle_ready; i++) begin
            @(negedge clk);
            if (!bundle_ready) stall++;
        end
        chk("R8 stall length", 32'(stall), 32'd32);
        chk_reg("R8 quotient 500/7", 26, 32'd71);
        chk_reg("R12 dropped bundle never lands", 27, 32'd0);
        issue(bun('0, '0, '0, '0, sl(DIVU, 29, 23, 0), 2'd0, 5'd0, 16'd0));
        wait_ready();
        chk_reg("R8 divide by zero", 29, 32'hFFFF_FFFF);
        issue(bun('0, '0, '0, '0, sl(DIVU, 10, 1, 24), 2'd0, 5'd0, 16'd0));
        wait_ready();
        chk_reg("R8 unsigned dividend", 10, 32'h2492_4924);
        chk("R11 pc after stalls", 32'(pc), 32'(exp_pc));
    endtask

    task automatic f2i_case(input string tag, input logic [31:0] bits, input logic [31:0] exp);
        load_const(3, bits);
        issue(bun('0, '0, '0, '0, sl(F2I, 4, 3, 0), 2'd0, 5'd0, 16'd0));
        chk_reg(tag, 4, exp);
    endtask

    task automatic t_f2i();
        f2i_case("R9 pi truncates", 32'h4049_0FDB, 32'd3);
        f2i_case("R9 -7.0", 32'hC0E0_0000, 32'hFFFF_FFF9);
        f2i_case("R9 0.5 to zero", 32'h3F00_0000, 32'd0);
        f2i_case("R9 denormal", 32'h0040_0000, 32'd0);
        f2i_case("R9 negative denormal", 32'h8040_0000, 32'd0);
        f2i_case("R9 2^23+1", 32'h4B00_0001, 32'h0080_0001);
        f2i_case("R9 2^30+128", 32'h4E80_0001, 32'h4000_0080);
        f2i_case("R10 2^31 saturates", 32'h4F00_0000, 32'h7FFF_FFFF);
        f2i_case("R10 -2^31", 32'hCF00_0000, 32'h8000_0000);
        f2i_case("R10 +inf", 32'h7F80_0000, 32'h7FFF_FFFF);
        f2i_case("R10 -inf", 32'hFF80_0000, 32'h8000_0000);
        f2i_case("R10 NaN", 32'h7FC0_0000, 32'd0);
    endtask

    task automatic t_branch();
        issue(bun('0, '0, '0, '0, '0, 2'd1, 5'd0, 16'h0100));
        chk("R11 zero-test taken", 32'(pc), 32'h100);
        issue(bun('0, '0, '0, '0, '0, 2'd1, 5'd1, 16'h0500));
        chk("R11 zero-test not taken", 32'(pc), 32'h101);
        issue(bun('0, '0, '0, '0, '0, 2'd2, 5'd1, 16'h0200));
        chk("R11 nonzero-test taken", 32'(pc), 32'h200);
        issue(bun('0, '0, '0, '0, '0, 2'd2, 5'd0, 16'h0600));
        chk("R11 nonzero-test not taken", 32'(pc), 32'h201);
        issue(bun(ldi(28, 1), '0, '0, '0, '0, 2'd1, 5'd28, 16'h0300));
        chk("R4 branch sees pre-bundle value", 32'(pc), 32'h300);
        chk_reg("R4 same-bundle write landed", 28, 32'd1);
        issue(bun('0, '0, '0, '0, '0, 2'd0, 5'd0, 16'h0999));
        chk("R11 mode 0 ignores target", 32'(pc), 32'h301);
        @(negedge clk);
        bundle = bun(ldi(28, 0), '0, '0, '0, '0, 2'd3, 5'd0, 16'h0ABC);
        repeat (3) @(negedge clk);
        chk("R12 valid low pc held", 32'(pc), 32'h301);
        chk_reg("R12 valid low reg held", 28, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog (all R): got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n        = 1'b0;
        bundle_valid = 1'b0;
        bundle       = '0;
        dbg_addr     = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_general();
        t_swap();
        t_conflict();
        t_unsupported();
        t_mul_shift();
        t_div();
        t_f2i();
        t_branch();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule